// File: doc/BRIEF.md
# Split-Source Miss Status Handler

This block tracks last-level cache misses whose eight-word line is held in two memories. Word 0 sits in a small, fast memory and carries one even-parity bit. Words 1 through 7, together with the ECC that protects the whole line, sit in a slow, low-power memory. Each new miss takes a free tracking entry and sends two requests in the same cycle, one to each memory controller. Responses come back tagged with the entry index, in either order.

The requested (critical) word goes to the core as early as it can be trusted. If that word is word 0 and its parity checks out, it leaves as soon as the fast response lands. Otherwise the block waits for the slow response, which brings the ECC verdict and a corrected copy of word 0. A fill carrying all eight words goes to the cache once both halves are present and every pending core request on that entry has been served; the fill releases the entry. A later miss to a line that is still in flight joins the existing entry instead of allocating a new one.

Top module: `split_miss_tracker`

## Requirements
- R1: Accepting a miss that matches no live entry raises `fast_req_valid` and `slow_req_valid` in that same cycle, with the same entry index and `miss_line` on both.
- R2: When the critical word is word 0 and the fast response has even parity (`fast_rsp_par` equals the XOR of all bits of `fast_rsp_word`), the word appears on `core_*` in the cycle after the fast response, without waiting for the slow response.
- R3: A critical word from 1 to 7 is never forwarded before the slow response. It is forwarded in the cycle after that response.
- R4: A parity mismatch on word 0 holds the word back. After the slow response, the corrected value `slow_rsp_w0_fix` is forwarded in place of the received value.
- R5: `fill_valid` rises only after both responses of an entry have arrived and its pending core requests are served. `fill_data` carries word i at bits [i*32 +: 32], with word 0 taken from `slow_rsp_w0_fix`.
- R6: A two-bit error in word 0 leaves its parity intact and is forwarded early with `core_err` low. When the slow response reports `slow_rsp_ecc_ok` low, the fill still raises `fill_err`.
- R7: There are four entries. With all four live and the incoming miss matching none of them, `miss_ready` is low and no request is issued. Out of reset `miss_ready` is high and no output is valid.
- R8: The fast and slow responses of an entry may arrive in either order or in the same cycle, and the forwarded word and the fill come out the same in each case.
- R9: A miss to a line still in flight is accepted even when every entry is live, issues no new request, and is served from the existing entry: at once if its word is already usable, otherwise when that word arrives.
- R10: When `slow_rsp_ecc_ok` is low, `fill_err` rises with the fill, and `core_err` rises with every word forwarded after the slow response. The fill frees the entry for a new miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A core access that missed in the cache |
| miss_ready | output | 1 | The miss is accepted in this cycle |
| miss_line | input | 26 | Line address of the miss |
| miss_word | input | 3 | Word of the line the core wants |
| fast_req_valid | output | 1 | Request for word 0 to the fast controller |
| fast_req_idx | output | 2 | Entry tag for the fast request |
| fast_req_line | output | 26 | Line address for the fast request |
| slow_req_valid | output | 1 | Request for words 1 to 7 and ECC to the slow controller |
| slow_req_idx | output | 2 | Entry tag for the slow request |
| slow_req_line | output | 26 | Line address for the slow request |
| fast_rsp_valid | input | 1 | Word 0 returned |
| fast_rsp_idx | input | 2 | Entry tag of the fast response |
| fast_rsp_word | input | 32 | Word 0 as read |
| fast_rsp_par | input | 1 | Stored even-parity bit of word 0 |
| slow_rsp_valid | input | 1 | Words 1 to 7 returned with the ECC verdict |
| slow_rsp_idx | input | 2 | Entry tag of the slow response |
| slow_rsp_words | input | 224 | Words 1 to 7, word 1 in the low 32 bits |
| slow_rsp_w0_fix | input | 32 | Word 0 after ECC correction |
| slow_rsp_ecc_ok | input | 1 | High when the line is clean or was corrected |
| core_valid | output | 1 | A word is forwarded to the core |
| core_idx | output | 2 | Entry that supplies the word |
| core_line | output | 26 | Line address of the forwarded word |
| core_word | output | 3 | Word index within the line |
| core_data | output | 32 | Forwarded word |
| core_err | output | 1 | The line's ECC reported an uncorrectable error |
| fill_valid | output | 1 | Complete line written to the cache; the entry is released |
| fill_idx | output | 2 | Entry being filled |
| fill_line | output | 26 | Line address of the fill |
| fill_data | output | 256 | Eight words, word 0 in the low 32 bits |
| fill_err | output | 1 | The fill carries an uncorrectable line |

## Verification
A core forward from one entry and the fill of another entry can occur in the same cycle, because forwards and fills have separate arbiters. The bench provokes this with two in-flight lines. Line A waits for its slow response. Line B has already forwarded its critical word and waits only for its fast response. Both missing responses are then driven in one cycle. The bench records the cycle of each core event and each fill event. It expects line A's word and line B's fill in the same cycle, with the correct line, word and data on each.

// File: rtl/smt_pkg.sv
package smt_pkg;

    // Words in one cache line; word 0 is the one held by the fast memory.
    localparam int LINE_WORDS = 8;

    // Trust level of word 0 inside an entry.
    typedef enum logic [1:0] {
        W0_NONE    = 2'd0,   // fast response not yet seen
        W0_CLEAN   = 2'd1,   // parity matched, usable at once
        W0_SUSPECT = 2'd2    // parity mismatch, wait for ECC
    } w0_state_e;

endpackage

// File: rtl/smt_pick_first.sv
module smt_pick_first #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/smt_word_ready.sv
module smt_word_ready
    import smt_pkg::*;
#(
    parameter int WORDS = LINE_WORDS
) (
    input  w0_state_e        w0,
    input  logic             rest,
    input  logic [WORDS-1:0] want,
    output logic [WORDS-1:0] serve,
    output logic             complete
);
    logic [WORDS-1:0] usable;

    always_comb begin
        usable[0]         = (w0 == W0_CLEAN) || ((w0 == W0_SUSPECT) && rest);
        usable[WORDS-1:1] = {(WORDS-1){rest}};
        serve             = want & usable;
        complete          = (w0 != W0_NONE) && rest;
    end
endmodule

// File: rtl/split_miss_tracker.sv
module split_miss_tracker
    import smt_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int WORD_W  = 32,
    parameter int LINE_W  = 26,
    localparam int WORDS  = LINE_WORDS,
    localparam int IDX_W  = $clog2(NUM_ENT),
    localparam int SEL_W  = $clog2(WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        miss_valid,
    output logic                        miss_ready,
    input  logic [LINE_W-1:0]           miss_line,
    input  logic [SEL_W-1:0]            miss_word,
    output logic                        fast_req_valid,
    output logic [IDX_W-1:0]            fast_req_idx,
    output logic [LINE_W-1:0]           fast_req_line,
    output logic                        slow_req_valid,
    output logic [IDX_W-1:0]            slow_req_idx,
    output logic [LINE_W-1:0]           slow_req_line,
    input  logic                        fast_rsp_valid,
    input  logic [IDX_W-1:0]            fast_rsp_idx,
    input  logic [WORD_W-1:0]           fast_rsp_word,
    input  logic                        fast_rsp_par,
    input  logic                        slow_rsp_valid,
    input  logic [IDX_W-1:0]            slow_rsp_idx,
    input  logic [(WORDS-1)*WORD_W-1:0] slow_rsp_words,
    input  logic [WORD_W-1:0]           slow_rsp_w0_fix,
    input  logic                        slow_rsp_ecc_ok,
    output logic                        core_valid,
    output logic [IDX_W-1:0]            core_idx,
    output logic [LINE_W-1:0]           core_line,
    output logic [SEL_W-1:0]            core_word,
    output logic [WORD_W-1:0]           core_data,
    output logic                        core_err,
    output logic                        fill_valid,
    output logic [IDX_W-1:0]            fill_idx,
    output logic [LINE_W-1:0]           fill_line,
    output logic [WORDS*WORD_W-1:0]     fill_data,
    output logic                        fill_err
);

    typedef struct packed {
        logic                          vld;
        logic [LINE_W-1:0]             line;
        w0_state_e                     w0;
        logic                          rest;
        logic                          err;
        logic [WORDS-1:0]              want;
        logic [WORDS-1:0][WORD_W-1:0]  data;
    } ent_t;

    typedef struct packed {
        ent_t [NUM_ENT-1:0] ent;
    } state_t;

    state_t state_d, state_q;

    // Per-entry readiness
    logic [NUM_ENT-1:0][WORDS-1:0] serve;
    logic [NUM_ENT-1:0]            complete;
    logic [NUM_ENT-1:0]            has_serve;
    logic [NUM_ENT-1:0]            fill_cand;
    logic [NUM_ENT-1:0]            hit_vec;
    logic [NUM_ENT-1:0]            free_vec;

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        smt_word_ready #(.WORDS(WORDS)) u_rdy (
            .w0       (state_q.ent[e].w0),
            .rest     (state_q.ent[e].rest),
            .want     (state_q.ent[e].want),
            .serve    (serve[e]),
            .complete (complete[e])
        );
        assign has_serve[e] = state_q.ent[e].vld && (|serve[e]);
        assign fill_cand[e] = state_q.ent[e].vld && complete[e] && (state_q.ent[e].want == '0);
        assign free_vec[e]  = !state_q.ent[e].vld;
        assign hit_vec[e]   = state_q.ent[e].vld && (state_q.ent[e].line == miss_line)
                              && !(fill_valid && (fill_idx == IDX_W'(e)));
    end

    // Forward arbitration: lowest entry, then lowest word
    logic             fwd_found;
    logic [IDX_W-1:0] fwd_ent;
    logic             fwd_wfound;
    logic [SEL_W-1:0] fwd_word;

    smt_pick_first #(.N(NUM_ENT)) u_fwd_ent (.req(has_serve), .found(fwd_found), .idx(fwd_ent));
    smt_pick_first #(.N(WORDS))   u_fwd_wrd (.req(serve[fwd_ent]), .found(fwd_wfound), .idx(fwd_word));

    // Fill arbitration, merge lookup and free-slot search
    logic             fill_found, hit_found, free_found;
    logic [IDX_W-1:0] fill_ent, hit_ent, free_ent;

    smt_pick_first #(.N(NUM_ENT)) u_fill (.req(fill_cand), .found(fill_found), .idx(fill_ent));
    smt_pick_first #(.N(NUM_ENT)) u_hit  (.req(hit_vec),   .found(hit_found),  .idx(hit_ent));
    smt_pick_first #(.N(NUM_ENT)) u_free (.req(free_vec),  .found(free_found), .idx(free_ent));

    logic alloc;
    logic par_ok;

    always_comb begin
        core_valid = fwd_found && fwd_wfound;
        core_idx   = fwd_ent;
        core_word  = fwd_word;
        core_line  = state_q.ent[fwd_ent].line;
        core_data  = state_q.ent[fwd_ent].data[fwd_word];
        core_err   = state_q.ent[fwd_ent].err;

        fill_valid = fill_found;
        fill_idx   = fill_ent;
        fill_line  = state_q.ent[fill_ent].line;
        fill_data  = state_q.ent[fill_ent].data;
        fill_err   = state_q.ent[fill_ent].err;

        miss_ready     = hit_found || free_found;
        alloc          = miss_valid && !hit_found && free_found;
        fast_req_valid = alloc;
        fast_req_idx   = free_ent;
        fast_req_line  = miss_line;
        slow_req_valid = alloc;
        slow_req_idx   = free_ent;
        slow_req_line  = miss_line;

        par_ok = ((^fast_rsp_word) == fast_rsp_par);
    end

    always_comb begin
        state_d = state_q;

        if (fast_rsp_valid) begin
            state_d.ent[fast_rsp_idx].w0 = par_ok ? W0_CLEAN : W0_SUSPECT;
            if (!state_q.ent[fast_rsp_idx].rest) begin
                state_d.ent[fast_rsp_idx].data[0] = fast_rsp_word;
            end
        end

        if (slow_rsp_valid) begin
            state_d.ent[slow_rsp_idx].rest    = 1'b1;
            state_d.ent[slow_rsp_idx].err     = !slow_rsp_ecc_ok;
            state_d.ent[slow_rsp_idx].data[0] = slow_rsp_w0_fix;
            for (int w = 1; w < WORDS; w++) begin
                state_d.ent[slow_rsp_idx].data[w] = slow_rsp_words[(w-1)*WORD_W +: WORD_W];
            end
        end

        if (core_valid) begin
            state_d.ent[fwd_ent].want[fwd_word] = 1'b0;
        end

        if (miss_valid && hit_found) begin
            state_d.ent[hit_ent].want[miss_word] = 1'b1;
        end

        if (fill_valid) begin
            state_d.ent[fill_ent] = '0;
        end

        if (alloc) begin
            state_d.ent[free_ent]      = '0;
            state_d.ent[free_ent].vld  = 1'b1;
            state_d.ent[free_ent].line = miss_line;
            state_d.ent[free_ent].want = WORDS'(1) << miss_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/smt_checker.sv
module smt_checker #(
    parameter int NUM_ENT = 4,
    parameter int WORD_W  = 32,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic              fast_req_valid,
    input logic [IDX_W-1:0]  fast_req_idx,
    input logic              slow_req_valid,
    input logic [IDX_W-1:0]  slow_req_idx,
    input logic              fast_rsp_valid,
    input logic [IDX_W-1:0]  fast_rsp_idx,
    input logic [WORD_W-1:0] fast_rsp_word,
    input logic              fast_rsp_par,
    input logic              slow_rsp_valid,
    input logic [IDX_W-1:0]  slow_rsp_idx,
    input logic              core_valid,
    input logic [IDX_W-1:0]  core_idx,
    input logic [2:0]        core_word,
    input logic              fill_valid,
    input logic [IDX_W-1:0]  fill_idx
);
    logic [NUM_ENT-1:0] occ, got_fast, got_slow, fast_good;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ       <= '0;
            got_fast  <= '0;
            got_slow  <= '0;
            fast_good <= '0;
        end else begin
            if (fast_req_valid) begin
                occ[fast_req_idx]       <= 1'b1;
                got_fast[fast_req_idx]  <= 1'b0;
                got_slow[fast_req_idx]  <= 1'b0;
                fast_good[fast_req_idx] <= 1'b0;
            end
            if (fast_rsp_valid) begin
                got_fast[fast_rsp_idx]  <= 1'b1;
                fast_good[fast_rsp_idx] <= ((^fast_rsp_word) == fast_rsp_par);
            end
            if (slow_rsp_valid) begin
                got_slow[slow_rsp_idx] <= 1'b1;
            end
            if (fill_valid) begin
                occ[fill_idx] <= 1'b0;
            end
        end
    end

    assert_paired_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fast_req_valid |-> (slow_req_valid && (slow_req_idx == fast_req_idx)));

    assert_alloc_free_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fast_req_valid |-> !occ[fast_req_idx]);

    assert_stall_only_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !miss_ready) |-> ($countones(occ) == NUM_ENT));

    assert_early_word0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && (core_word == 3'd0) && !got_slow[core_idx])
            |-> (got_fast[core_idx] && fast_good[core_idx]));

    assert_late_words_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && (core_word != 3'd0)) |-> got_slow[core_idx]);

    assert_fill_complete_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (occ[fill_idx] && got_fast[fill_idx] && got_slow[fill_idx]));

endmodule

bind split_miss_tracker smt_checker #(.NUM_ENT(NUM_ENT), .WORD_W(WORD_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_valid     (miss_valid),
    .miss_ready     (miss_ready),
    .fast_req_valid (fast_req_valid),
    .fast_req_idx   (fast_req_idx),
    .slow_req_valid (slow_req_valid),
    .slow_req_idx   (slow_req_idx),
    .fast_rsp_valid (fast_rsp_valid),
    .fast_rsp_idx   (fast_rsp_idx),
    .fast_rsp_word  (fast_rsp_word),
    .fast_rsp_par   (fast_rsp_par),
    .slow_rsp_valid (slow_rsp_valid),
    .slow_rsp_idx   (slow_rsp_idx),
    .core_valid     (core_valid),
    .core_idx       (core_idx),
    .core_word      (core_word),
    .fill_valid     (fill_valid),
    .fill_idx       (fill_idx)
);

// File: tb/split_miss_tracker_tb.sv
module split_miss_tracker_tb;
    localparam int NE = 4;
    localparam int W  = 32;
    localparam int LW = 26;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic miss_valid, miss_ready;
    logic [LW-1:0] miss_line;
    logic [2:0] miss_word;
    logic fast_req_valid, slow_req_valid;
    logic [1:0] fast_req_idx, slow_req_idx;
    logic [LW-1:0] fast_req_line, slow_req_line;
    logic fast_rsp_valid, fast_rsp_par;
    logic [1:0] fast_rsp_idx;
    logic [W-1:0] fast_rsp_word;
    logic slow_rsp_valid, slow_rsp_ecc_ok;
    logic [1:0] slow_rsp_idx;
    logic [7*W-1:0] slow_rsp_words;
    logic [W-1:0] slow_rsp_w0_fix;
    logic core_valid, core_err, fill_valid, fill_err;
    logic [1:0] core_idx, fill_idx;
    logic [LW-1:0] core_line, fill_line;
    logic [2:0] core_word;
    logic [W-1:0] core_data;
    logic [8*W-1:0] fill_data;

    split_miss_tracker u_dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line(miss_line), .miss_word(miss_word),
        .fast_req_valid(fast_req_valid), .fast_req_idx(fast_req_idx), .fast_req_line(fast_req_line),
        .slow_req_valid(slow_req_valid), .slow_req_idx(slow_req_idx), .slow_req_line(slow_req_line),
        .fast_rsp_valid(fast_rsp_valid), .fast_rsp_idx(fast_rsp_idx), .fast_rsp_word(fast_rsp_word),
        .fast_rsp_par(fast_rsp_par),
        .slow_rsp_valid(slow_rsp_valid), .slow_rsp_idx(slow_rsp_idx), .slow_rsp_words(slow_rsp_words),
        .slow_rsp_w0_fix(slow_rsp_w0_fix), .slow_rsp_ecc_ok(slow_rsp_ecc_ok),
        .core_valid(core_valid), .core_idx(core_idx), .core_line(core_line), .core_word(core_word),
        .core_data(core_data), .core_err(core_err),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_line(fill_line), .fill_data(fill_data),
        .fill_err(fill_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] val(input int line, input int w);
        return 32'hA500_0000 ^ W'(line << 4) ^ W'(w);
    endfunction

    // Event monitor, sampled mid-cycle
    int cyc = 0;
    int fwd_n = 0, fill_n = 0, fwd_cyc = -1, fill_cyc = -1;
    logic [W-1:0] fwd_data;
    logic [2:0] fwd_word;
    logic fwd_err, fill_e;
    logic [LW-1:0] fwd_line, fill_l;
    logic [8*W-1:0] fill_d;
    logic [1:0] last_idx;

    always @(negedge clk) begin
        cyc++;
        if (fast_req_valid) last_idx = fast_req_idx;
        if (core_valid) begin
            fwd_n++; fwd_cyc = cyc; fwd_data = core_data; fwd_word = core_word;
            fwd_err = core_err; fwd_line = core_line;
        end
        if (fill_valid) begin
            fill_n++; fill_cyc = cyc; fill_e = fill_err; fill_l = fill_line; fill_d = fill_data;
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic miss(input int line, input int w, output logic [1:0] idx);
        miss_valid = 1'b1; miss_line = LW'(line); miss_word = 3'(w);
        step();
        miss_valid = 1'b0;
        idx = last_idx;
    endtask

    // mode: 0 good parity, 1 single flip, 2 double flip
    task automatic respond(input logic df, input logic [1:0] fi, input int fl, input int mode,
                           input logic ds, input logic [1:0] si, input int sl, input logic ok);
        logic [W-1:0] t;
        t = val(fl, 0);
        fast_rsp_valid = df; fast_rsp_idx = fi; fast_rsp_par = ^t;
        fast_rsp_word  = (mode == 1) ? (t ^ 32'h1) : (mode == 2) ? (t ^ 32'h3) : t;
        slow_rsp_valid = ds; slow_rsp_idx = si; slow_rsp_ecc_ok = ok;
        slow_rsp_w0_fix = val(sl, 0);
        for (int w = 1; w < 8; w++) slow_rsp_words[(w-1)*W +: W] = val(sl, w);
        step();
        fast_rsp_valid = 1'b0; slow_rsp_valid = 1'b0;
    endtask

    task automatic report();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    typedef struct packed {
        logic [2:0] w;     // critical word
        logic       pg;    // fast word parity good
        logic [1:0] ord;   // 0 fast first, 1 slow first, 2 same cycle
        logic       ok;    // ECC verdict
    } vec_t;

    localparam vec_t VEC [0:6] = '{
        '{3'd0, 1'b1, 2'd0, 1'b1},
        '{3'd0, 1'b0, 2'd0, 1'b1},
        '{3'd3, 1'b1, 2'd0, 1'b1},
        '{3'd5, 1'b1, 2'd1, 1'b1},
        '{3'd0, 1'b1, 2'd1, 1'b1},
        '{3'd0, 1'b1, 2'd2, 1'b0},
        '{3'd7, 1'b0, 2'd2, 1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
    end

    initial begin
        logic [1:0] ia [4];
        logic [1:0] ix, ib;
        int fb, lb;
        rst_n = 1'b0; miss_valid = 1'b0; miss_line = '0; miss_word = '0;
        fast_rsp_valid = 1'b0; fast_rsp_idx = '0; fast_rsp_word = '0; fast_rsp_par = 1'b0;
        slow_rsp_valid = 1'b0; slow_rsp_idx = '0; slow_rsp_words = '0; slow_rsp_w0_fix = '0;
        slow_rsp_ecc_ok = 1'b1;
        step(3);
        rst_n = 1'b1;
        step();

        // Reset state (R7)
        chk("R7 reset miss_ready", miss_ready, 1);
        chk("R7 reset core_valid", core_valid, 0);
        chk("R7 reset fill_valid", fill_valid, 0);

        // Allocation issues both requests (R1)
        miss_valid = 1'b1; miss_line = 26'd77; miss_word = 3'd0; #1;
        chk("R1 fast/slow together", {fast_req_valid, slow_req_valid}, 2'b11);
        chk("R1 same index and line", {slow_req_idx == fast_req_idx, slow_req_line == fast_req_line,
                                      fast_req_line == 26'd77}, 3'b111);
        step(); miss_valid = 1'b0; ix = last_idx;
        respond(1, ix, 77, 0, 1, ix, 77, 1);
        step(3);

        // Table-driven orderings (R2, R3, R4, R8, R10)
        for (int i = 0; i < 7; i++) begin
            int line;
            logic early;
            line = 100 + i;
            early = (VEC[i].ord == 2'd0) && (VEC[i].w == 3'd0) && VEC[i].pg;
            miss(line, VEC[i].w, ix);
            fb = fwd_n; lb = fill_n;
            if (VEC[i].ord == 2'd0) begin
                respond(1, ix, line, VEC[i].pg ? 0 : 1, 0, ix, line, 1);
                step(2);
                chk("R2/R3/R4 forward before slow", fwd_n - fb, {63'd0, early});
                respond(0, ix, line, 0, 1, ix, line, VEC[i].ok);
            end else if (VEC[i].ord == 2'd1) begin
                respond(0, ix, line, 0, 1, ix, line, VEC[i].ok);
                step(2);
                chk("R3/R8 forward before fast", fwd_n - fb, {63'd0, VEC[i].w != 3'd0});
                respond(1, ix, line, VEC[i].pg ? 0 : 1, 0, ix, line, 1);
            end else begin
                respond(1, ix, line, VEC[i].pg ? 0 : 1, 1, ix, line, VEC[i].ok);
            end
            step(3);
            chk("R8 one forward", fwd_n - fb, 1);
            chk("R2/R3/R4 forwarded data", fwd_data, val(line, VEC[i].w));
            chk("R10 core_err", fwd_err, early ? 1'b0 : !VEC[i].ok);
            chk("R5 one fill", fill_n - lb, 1);
            chk("R5 fill word0 corrected", fill_d[W-1:0], val(line, 0));
            chk("R5 fill word7", fill_d[7*W +: W], val(line, 7));
            chk("R10 fill_err", fill_e, !VEC[i].ok);
        end

        // Full table and merge (R7, R9, R10)
        for (int k = 0; k < 4; k++) miss(200 + k, k + 1, ia[k]);
        miss_valid = 1'b1; miss_line = 26'd204; miss_word = 3'd0; #1;
        chk("R7 full stalls new line", miss_ready, 0);
        chk("R7 no request when full", fast_req_valid, 0);
        miss_line = 26'd201; miss_word = 3'd6; #1;
        chk("R9 merge accepted when full", miss_ready, 1);
        chk("R9 merge issues no request", fast_req_valid, 0);
        step(); miss_valid = 1'b0;
        fb = fwd_n; lb = fill_n;
        respond(1, ia[1], 201, 0, 1, ia[1], 201, 1);
        step(4);
        chk("R9 merged word served on arrival", fwd_n - fb, 2);
        chk("R9 last merged word", {fwd_word, fwd_data}, {3'd6, val(201, 6)});
        chk("R10 entry freed by fill", fill_n - lb, 1);
        miss_valid = 1'b1; miss_line = 26'd204; miss_word = 3'd0; #1;
        chk("R10 freed entry reusable", miss_ready, 1);
        step(); miss_valid = 1'b0; ia[1] = last_idx;
        for (int k = 0; k < 4; k++) begin
            respond(1, ia[k], (k == 1) ? 204 : 200 + k, 0, 1, ia[k], (k == 1) ? 204 : 200 + k, 1);
        end
        step(4);

        // Merge onto a word already present (R9)
        miss(300, 3, ix);
        fb = fwd_n;
        respond(1, ix, 300, 0, 0, ix, 300, 1);
        step(2);
        miss(300, 0, ix);
        step(2);
        chk("R9 present word served at once", fwd_n - fb, 1);
        chk("R9 present word value", {fwd_word, fwd_data}, {3'd0, val(300, 0)});
        miss(300, 5, ix);
        step(2);
        chk("R9 absent word waits", fwd_n - fb, 1);
        respond(0, ix, 300, 0, 1, ix, 300, 1);
        step(4);
        chk("R9 waiting words served after slow", fwd_n - fb, 3);

        // Double-bit error in word 0 (R6)
        miss(400, 0, ix);
        fb = fwd_n; lb = fill_n;
        respond(1, ix, 400, 2, 0, ix, 400, 1);
        step(2);
        chk("R6 double-bit word forwarded early", fwd_n - fb, 1);
        chk("R6 forwarded raw data", {fwd_err, fwd_data}, {1'b0, val(400, 0) ^ 32'h3});
        respond(0, ix, 400, 0, 1, ix, 400, 0);
        step(3);
        chk("R6 fill flags error", {fill_n - lb == 1, fill_e}, 2'b11);
        chk("R6 fill carries corrected word0", fill_d[W-1:0], val(400, 0));

        // Forward and fill in one cycle (R5, R8)
        miss(500, 2, ix);
        miss(501, 4, ib);
        respond(0, ib, 501, 0, 1, ib, 501, 1);
        step(2);
        respond(1, ib, 501, 0, 1, ix, 500, 1);
        step(3);
        chk("R8 concurrent forward and fill", fwd_cyc == fill_cyc, 1);
        chk("R8 forwarded word", {fwd_line, fwd_word, fwd_data}, {26'd500, 3'd2, val(500, 2)});
        chk("R5 concurrent fill line", fill_l, 26'd501);
        respond(1, ix, 500, 0, 0, ix, 500, 1);
        step(3);
        chk("R5 trailing fill", fill_l, 26'd500);

        report();
    end
endmodule